// File: doc/BRIEF.md
# Shared System Bus Controller

This block connects one bus master to a small set of slave modules over a shared, synchronous bus. The master raises one of four command strobes: memory read, memory write, I/O read or I/O write. With the strobe it presents an address and, for writes, write data. The controller takes the top address bits as a module code. It looks that code up in one of two decode tables: one for memory space, one for I/O space. The table lookup selects at most one slave. The remaining low address bits go to that slave as a local offset.

A cycle ends only when the selected slave returns a transfer acknowledge. That acknowledge reaches the master in the same clock, together with the slave's read data. The slave may take as many cycles as it needs.

An access whose code is unpopulated in the table for its space selects no slave. The controller ends such an access itself after a fixed number of clocks. It raises the acknowledge and an error flag, and for a read it returns all ones. The read-data path drives zero whenever no read is in progress, so the shared bus never floats.

Top module: `sysbus_ctrl`

## Requirements
- R1: A memory command uses the memory table. Entry k of that table is 3 bits wide: bit 2 marks it populated and bits 1:0 name the slave. The code k is the top two address bits, addr[15:14]. With default parameters, memory code 0 selects slave 0, memory code 1 selects slave 1, and codes 2 and 3 are empty. At most one bit of `s_sel` is ever high.
- R2: An I/O command uses the separate I/O table. With default parameters, I/O code 0 selects slave 2 and I/O code 1 selects slave 3. The same address under a memory command and under an I/O command therefore reaches different slaves.
- R3: While an access hits, `s_offset` equals addr[13:0] and `s_wdata` equals the write data. `s_rd` is high for either read command, `s_wr` for either write command, and `s_io` for either I/O command. Only one master strobe is high at a time. The master holds its strobe, address and data stable until the acknowledge.
- R4: A hitting access completes, with `m_ack` high, in the same cycle that the selected slave raises its bit of `s_ack`. Acknowledges from slaves that are not selected have no effect.
- R5: On the acknowledge cycle of a hitting read, `m_rdata` equals the selected slave's read data.
- R6: An access that selects no slave leaves `s_sel` at zero. It completes with `m_ack` and `m_err` both high in the eighth clock of the access, counting the cycle in which the strobe first appears as the first. A read ends with `m_rdata` all ones. Slave acknowledges do not shorten the wait.
- R7: `m_rdata` is zero whenever neither read strobe is high, including during writes.
- R8: While reset is low, the timeout count is cleared, so an unmatched access restarts its full eight-clock wait after reset is released. With no command present, `m_ack`, `m_err`, `s_sel` and `m_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_mem_rd | input | 1 | Master memory read strobe |
| m_mem_wr | input | 1 | Master memory write strobe |
| m_io_rd | input | 1 | Master I/O read strobe |
| m_io_wr | input | 1 | Master I/O write strobe |
| m_addr | input | AW | Master address; top SELW bits are the module code |
| m_wdata | input | DW | Master write data |
| m_rdata | output | DW | Read data returned to the master |
| m_ack | output | 1 | Access complete |
| m_err | output | 1 | Access ended by timeout (no slave decoded) |
| s_sel | output | NS | One-hot slave select |
| s_rd | output | 1 | Read command to the selected slave |
| s_wr | output | 1 | Write command to the selected slave |
| s_io | output | 1 | Command is in I/O space |
| s_offset | output | AW-SELW | Local offset within the slave |
| s_wdata | output | DW | Write data to the slave |
| s_rdata | input | NS*DW | Read data of every slave, slave k at bits k*DW upward |
| s_ack | input | NS | Transfer acknowledge of every slave |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 32-bit data, four slaves, a two-bit module code and an eight-clock timeout. The default tables populate two memory codes and two I/O codes and leave the rest empty. This exposes both the memory/I/O split on one address and the timeout path in each space. The bench's slave models acknowledge after a delay equal to their own index plus one, so each of the four slaves completes at a different cycle. Stray acknowledges on unselected slaves and a reset in the middle of a timeout wait are also within reach.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;

   // Decoded command seen by the controller
   typedef struct packed {
      logic rd;
      logic wr;
      logic io;
   } bus_cmd_t;

   // Build one 3-bit table entry: populated flag over a 2-bit slave index
   function automatic logic [2:0] map_entry(input logic used, input logic [1:0] idx);
      return {used, idx};
   endfunction

endpackage

// File: rtl/sysbus_decode.sv
module sysbus_decode #(
   parameter int SELW = 2,
   parameter int NS   = 4,
   parameter int SIW  = 2,
   parameter int ENW  = 3,
   parameter logic [(2**SELW)*ENW-1:0] MEM_MAP = '0,
   parameter logic [(2**SELW)*ENW-1:0] IO_MAP  = '0
) (
   input  logic            valid,
   input  logic            io,
   input  logic [SELW-1:0] code,
   output logic [NS-1:0]   sel,
   output logic            hit
);
   logic [ENW-1:0] entry;

   always_comb begin
      if (io) entry = IO_MAP[int'(code)*ENW +: ENW];
      else    entry = MEM_MAP[int'(code)*ENW +: ENW];
   end

   for (genvar s = 0; s < NS; s++) begin : g_sel
      assign sel[s] = valid && entry[ENW-1] && (entry[SIW-1:0] == SIW'(s));
   end

   assign hit = |sel;

   // a single table entry can only ever name one slave
   always_comb begin
      assert_sel_onehot_R1: assert ($onehot0(sel));
   end
endmodule

// File: rtl/sysbus_timeout.sv
module sysbus_timeout #(
   parameter int TIMEOUT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic miss,
   output logic fire
);
   localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

   logic [CW-1:0] cnt;

   assign fire = miss && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (miss && !fire) cnt <= cnt + 1'b1;
      else                    cnt <= '0;
   end

   assert_count_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (miss && !fire) |=> (cnt == $past(cnt) + 1'b1));

   assert_fire_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt == '0));
endmodule

// File: rtl/sysbus_rdmux.sv
module sysbus_rdmux #(
   parameter int NS = 4,
   parameter int DW = 32
) (
   input  logic [NS-1:0]    sel,
   input  logic [NS*DW-1:0] rdata_flat,
   input  logic             rd_active,
   input  logic             timeout,
   output logic [DW-1:0]    rdata
);
   logic [DW-1:0] terms [NS];
   logic [DW-1:0] merged;

   for (genvar s = 0; s < NS; s++) begin : g_term
      assign terms[s] = sel[s] ? rdata_flat[s*DW +: DW] : '0;
   end

   always_comb begin
      merged = '0;
      for (int s = 0; s < NS; s++) merged |= terms[s];
   end

   always_comb begin
      if (!rd_active)   rdata = '0;
      else if (timeout) rdata = '1;
      else              rdata = merged;
   end
endmodule

// File: rtl/sysbus_ctrl.sv
module sysbus_ctrl
   import sysbus_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DW      = 32,
   parameter int NS      = 4,
   parameter int SELW    = 2,
   parameter int TIMEOUT = 8,
   parameter logic [(2**SELW)*($clog2(NS)+1)-1:0] MEM_MAP = 12'b000_000_101_100,
   parameter logic [(2**SELW)*($clog2(NS)+1)-1:0] IO_MAP  = 12'b000_000_111_110
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                m_mem_rd,
   input  logic                m_mem_wr,
   input  logic                m_io_rd,
   input  logic                m_io_wr,
   input  logic [AW-1:0]       m_addr,
   input  logic [DW-1:0]       m_wdata,
   output logic [DW-1:0]       m_rdata,
   output logic                m_ack,
   output logic                m_err,
   output logic [NS-1:0]       s_sel,
   output logic                s_rd,
   output logic                s_wr,
   output logic                s_io,
   output logic [AW-SELW-1:0]  s_offset,
   output logic [DW-1:0]       s_wdata,
   input  logic [NS*DW-1:0]    s_rdata,
   input  logic [NS-1:0]       s_ack
);
   localparam int SIW = $clog2(NS);
   localparam int ENW = SIW + 1;
   localparam int OW  = AW - SELW;

   initial begin
      assert (NS >= 2) else $error("sysbus_ctrl: NS must be at least 2");
      assert (SELW >= 1 && SELW < AW) else $error("sysbus_ctrl: SELW out of range");
      assert (TIMEOUT >= 2) else $error("sysbus_ctrl: TIMEOUT must be at least 2");
   end

   bus_cmd_t        cmd;
   logic            cmd_any;
   logic [NS-1:0]   sel;
   logic            hit;
   logic            miss;
   logic            fire;
   logic            slave_done;

   assign cmd.rd  = m_mem_rd | m_io_rd;
   assign cmd.wr  = m_mem_wr | m_io_wr;
   assign cmd.io  = m_io_rd  | m_io_wr;
   assign cmd_any = cmd.rd | cmd.wr;

   sysbus_decode #(
      .SELW(SELW), .NS(NS), .SIW(SIW), .ENW(ENW),
      .MEM_MAP(MEM_MAP), .IO_MAP(IO_MAP)
   ) u_decode (
      .valid (cmd_any),
      .io    (cmd.io),
      .code  (m_addr[AW-1 -: SELW]),
      .sel   (sel),
      .hit   (hit)
   );

   assign miss = cmd_any && !hit;

   sysbus_timeout #(.TIMEOUT(TIMEOUT)) u_timeout (
      .clk   (clk),
      .rst_n (rst_n),
      .miss  (miss),
      .fire  (fire)
   );

   sysbus_rdmux #(.NS(NS), .DW(DW)) u_rdmux (
      .sel        (sel),
      .rdata_flat (s_rdata),
      .rd_active  (cmd.rd),
      .timeout    (fire),
      .rdata      (m_rdata)
   );

   assign slave_done = |(s_ack & sel);
   assign m_ack      = slave_done | fire;
   assign m_err      = fire;

   assign s_sel    = sel;
   assign s_rd     = cmd.rd & hit;
   assign s_wr     = cmd.wr & hit;
   assign s_io     = cmd.io & hit;
   assign s_offset = m_addr[OW-1:0];
   assign s_wdata  = m_wdata;

   assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({m_mem_rd, m_mem_wr, m_io_rd, m_io_wr}));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_any && !m_ack) |=> ($stable(m_addr) && $stable(m_wdata) &&
                                $stable({m_mem_rd, m_mem_wr, m_io_rd, m_io_wr})));

   assert_ack_needs_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      m_ack |-> cmd_any);

   assert_err_no_slave_R6: assert property (@(posedge clk) disable iff (!rst_n)
      m_err |-> (s_sel == '0 && m_ack));

   assert_rdata_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_mem_rd || m_io_rd) |-> (m_rdata == '0));
endmodule

// File: tb/tb_sysbus_ctrl.sv
module tb_sysbus_ctrl;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int NS = 4;
   localparam int OW = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_mem_rd = 0, m_mem_wr = 0, m_io_rd = 0, m_io_wr = 0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_wdata = '0;
   logic [DW-1:0] m_rdata;
   logic m_ack, m_err;
   logic [NS-1:0] s_sel;
   logic s_rd, s_wr, s_io;
   logic [OW-1:0] s_offset;
   logic [DW-1:0] s_wdata;
   logic [NS*DW-1:0] s_rdata;
   logic [NS-1:0] s_ack;
   logic [NS-1:0] ack_r;
   logic [NS-1:0] stray = '0;
   logic [3:0] wcnt [NS];
   logic [DW-1:0] smem [NS][16];
   logic [DW-1:0] exp_mem [NS][16];

   int total = 0;
   int bad = 0;

   typedef struct { logic [DW-1:0] rdata; logic err; string req; } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   sysbus_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .m_mem_rd(m_mem_rd), .m_mem_wr(m_mem_wr), .m_io_rd(m_io_rd), .m_io_wr(m_io_wr),
      .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack), .m_err(m_err),
      .s_sel(s_sel), .s_rd(s_rd), .s_wr(s_wr), .s_io(s_io), .s_offset(s_offset),
      .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ack(s_ack)
   );

   function automatic logic [DW-1:0] init_word(input int k, input int i);
      return 32'hA000_0000 | (k << 8) | i;
   endfunction

   // slave models: slave k acknowledges k+1 clocks after it is selected
   always @(posedge clk) begin
      for (int k = 0; k < NS; k++) begin
         if (!rst_n) begin
            ack_r[k] <= 1'b0;
            wcnt[k]  <= '0;
            for (int i = 0; i < 16; i++) smem[k][i] <= init_word(k, i);
         end else if (s_sel[k] && !ack_r[k]) begin
            if (wcnt[k] == 4'(k)) begin
               ack_r[k] <= 1'b1;
               wcnt[k]  <= '0;
               if (s_wr) smem[k][s_offset[3:0]] <= s_wdata;
            end else begin
               wcnt[k] <= wcnt[k] + 1'b1;
            end
         end else begin
            ack_r[k] <= 1'b0;
            wcnt[k]  <= '0;
         end
      end
   end

   for (genvar k = 0; k < NS; k++) begin : g_rd
      assign s_rdata[k*DW +: DW] = smem[k][s_offset[3:0]];
   end
   assign s_ack = ack_r | stray;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: pop expected completions as the design acknowledges
   always @(negedge clk) begin
      if (rst_n && m_ack) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R4", "unexpected ack", 32'(m_ack), 32'h0);
         end else begin
            item_t it;
            it = sb.pop_front();
            chk(m_rdata == it.rdata, it.req, "read data", m_rdata, it.rdata);
            chk(m_err == it.err, it.req, "error flag", 32'(m_err), 32'(it.err));
         end
      end
   end

   // expected slave: -1 when the code is unpopulated in that space
   function automatic int exp_slave(input bit io, input logic [AW-1:0] a);
      int code = int'(a[15:14]);
      if (code > 1) return -1;
      return io ? code + 2 : code;
   endfunction

   // kind: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write
   task automatic access(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic [NS-1:0] st, input string req);
      bit io = (kind >= 2);
      bit wr = (kind == 1 || kind == 3);
      int s  = exp_slave(io, a);
      int waits = 0;
      int exp_waits;
      item_t it;
      it.req = req;
      it.err = (s < 0);
      if (wr)         it.rdata = '0;
      else if (s < 0) it.rdata = '1;
      else            it.rdata = exp_mem[s][a[3:0]];
      if (wr && s >= 0) exp_mem[s][a[3:0]] = wd;
      exp_waits = (s < 0) ? 7 : s + 1;
      sb.push_back(it);
      @(negedge clk);
      m_mem_rd = (kind == 0); m_mem_wr = (kind == 1);
      m_io_rd  = (kind == 2); m_io_wr  = (kind == 3);
      m_addr = a; m_wdata = wd; stray = st;
      #1;
      chk(s_sel == ((s < 0) ? 4'b0 : 4'(1 << s)), (s < 0) ? "R6" : (io ? "R2" : "R1"),
          "slave select", 32'(s_sel), (s < 0) ? 32'h0 : 32'(1 << s));
      if (s >= 0) begin
         chk(s_offset == a[13:0], "R3", "offset", 32'(s_offset), 32'(a[13:0]));
         chk({s_rd, s_wr, s_io} == {!wr, wr, io}, "R3", "command lines",
             32'({s_rd, s_wr, s_io}), 32'({!wr, wr, io}));
         if (wr) chk(s_wdata == wd, "R3", "write data", s_wdata, wd);
      end
      if (wr) chk(m_rdata == '0, "R7", "rdata during write", m_rdata, '0);
      do begin
         @(negedge clk);
         waits++;
      end while (!m_ack && waits < 40);
      chk(waits == exp_waits, (s < 0) ? "R6" : "R4", "completion cycle",
          32'(waits), 32'(exp_waits));
      @(posedge clk);
      #1;
      m_mem_rd = 0; m_mem_wr = 0; m_io_rd = 0; m_io_wr = 0; stray = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < NS; k++)
         for (int i = 0; i < 16; i++) exp_mem[k][i] = init_word(k, i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!m_ack && !m_err, "R8", "idle ack/err", 32'({m_ack, m_err}), 32'h0);
      chk(s_sel == '0, "R8", "idle select", 32'(s_sel), 32'h0);
      chk(m_rdata == '0, "R7", "idle rdata", m_rdata, '0);

      // reads from each slave, both spaces (R1, R2, R5)
      access(0, 16'h0003, '0, '0, "R5");
      access(0, 16'h4005, '0, '0, "R5");
      access(2, 16'h0007, '0, '0, "R5");
      access(2, 16'h400A, '0, '0, "R5");
      // write then read back
      access(1, 16'h0003, 32'h1234_5678, '0, "R3");
      access(0, 16'h0003, '0, '0, "R5");
      access(3, 16'h4002, 32'hCAFE_F00D, '0, "R3");
      access(2, 16'h4002, '0, '0, "R2");
      // same address, memory space: slave 1 still holds its own word (R2)
      access(0, 16'h4002, '0, '0, "R2");
      // offset uses all low bits
      access(0, 16'h3FFF, '0, '0, "R3");
      // stray acknowledge on an unselected slave does not end the access (R4)
      access(2, 16'h4001, '0, 4'b0001, "R4");
      // unmapped codes in both spaces (R6)
      access(0, 16'h8000, '0, '0, "R6");
      access(3, 16'hC001, 32'hDEAD_BEEF, '0, "R6");
      access(0, 16'hC000, '0, 4'b1111, "R6");
      access(0, 16'h0001, '0, '0, "R5");

      // reset in the middle of a timeout wait restarts the count (R8)
      begin
         item_t it;
         int waits = 0;
         it.rdata = '1; it.err = 1'b1; it.req = "R8";
         sb.push_back(it);
         @(negedge clk);
         m_mem_rd = 1; m_addr = 16'h8004;
         repeat (4) @(negedge clk);
         rst_n = 1'b0;
         @(negedge clk);
         rst_n = 1'b1;
         for (int k = 0; k < NS; k++)
            for (int i = 0; i < 16; i++) exp_mem[k][i] = init_word(k, i);
         do begin
            @(negedge clk);
            waits++;
         end while (!m_ack && waits < 40);
         chk(waits == 7, "R8", "wait after reset", 32'(waits), 32'd7);
         @(posedge clk);
         #1;
         m_mem_rd = 0;
      end
      @(negedge clk);
      chk(!m_ack && m_rdata == '0, "R7", "idle after run", m_rdata, '0);
      chk(sb.size() == 0, "R4", "pending completions", 32'(sb.size()), 32'h0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule